// File: doc/BRIEF.md
# Multiplexed Flash Bus Cycle Decoder

This block is the device-side front end of an asynchronous flash interface in which commands, addresses and data all travel on one shared I/O bus. It oversamples the chip-enable, command-latch, address-latch, write-strobe, read-strobe and write-protect pins in the system clock domain. Every pin and every I/O bit passes through a synchronizer before any edge is detected. For each accepted write-strobe rising edge or read-strobe falling edge it issues a single-clock strobe. The strobe carries the cycle kind and the captured value.

Downstream logic such as a command interpreter or an array model consumes the strobe. The block also drives a standby level, a protocol-error pulse and a count of the address cycles accepted since the last command. The bus width is 8 or 16 bits. On a 16-bit bus the upper byte carries only data, so it must be zero during a command.

Top module: `nand_cycle_decoder`

## Requirements
- R1: While reset is held and after it is released, with idle pins, `cyc_valid`, `cyc_kind`, `proto_err` and `addr_count` are all 0.
- R2: A write-strobe rise with chip enable low, command latch high, address latch low and read strobe high gives one strobe of kind 1 (command). Its data is the low byte of the bus, zero-extended.
- R3: A write-strobe rise with chip enable low, address latch high and command latch low gives one strobe of kind 2 (address). Its data is the low byte, zero-extended.
- R4: A write-strobe rise with chip enable low and both latch enables low gives one strobe of kind 3 (data-in). Its data is the full bus word.
- R5: A read-strobe fall with chip enable low, both latch enables low and the write strobe high gives one strobe of kind 4 (data-out). Its data is 0.
- R6: On a 16-bit bus, a command cycle whose bits 15:8 are not all zero still gives its command strobe and also pulses `proto_err` for one clock.
- R7: While write protect is low, every write-strobe cycle that R2 to R4 would accept is instead reported as kind 5 (write-protected), with the full bus word as data. Such a cycle leaves `addr_count` unchanged.
- R8: While chip enable is high, write-strobe and read-strobe edges produce no strobe.
- R9: A write-strobe rise with chip enable low and both latch enables high, or with command latch high and read strobe low, produces no strobe and pulses `proto_err`.
- R10: `standby` is high when chip enable is high and `busy` is low. It is low when chip enable is low or `busy` is high.
- R11: An accepted command clears `addr_count` to 0. Each accepted address cycle adds 1, and the count saturates at its maximum value.
- R12: `cyc_valid` is high for exactly one clock per accepted edge, and `cyc_kind` is nonzero exactly when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low |
| cle | input | 1 | Command latch enable pin |
| ale | input | 1 | Address latch enable pin |
| we_n | input | 1 | Write strobe pin, active low |
| re_n | input | 1 | Read strobe pin, active low |
| wp_n | input | 1 | Write protect pin, active low |
| io_in | input | IO_W | Shared I/O bus |
| busy | input | 1 | Device busy with an internal operation |
| cyc_valid | output | 1 | One-clock cycle strobe |
| cyc_kind | output | 3 | Cycle kind: 1 command, 2 address, 3 data-in, 4 data-out, 5 write-protected, 0 none |
| cyc_data | output | IO_W | Value captured for the strobed cycle |
| proto_err | output | 1 | One-clock protocol error pulse |
| standby | output | 1 | Standby level |
| addr_count | output | ACNT_W | Address cycles accepted since the last command |

## Verification
The bench builds the decoder with `IO_W` = 16, so that the upper-byte check on command cycles and full-word data capture can be observed. It sets `ACNT_W` = 3, so that the address counter reaches saturation at 7 after a few cycles. `SYNC_STAGES` keeps its default of 2. With these values the latency from a pin change to a strobe is three clocks, and every strobe, error pulse and count falls inside a short observation window after each scenario.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
   typedef enum logic [2:0] {
      CK_NONE  = 3'd0,
      CK_CMD   = 3'd1,
      CK_ADDR  = 3'd2,
      CK_DIN   = 3'd3,
      CK_DOUT  = 3'd4,
      CK_WPROT = 3'd5
   } cyc_kind_e;

   // bit positions of the control pins inside the synchronized vector
   localparam int PIN_CE  = 0;
   localparam int PIN_CLE = 1;
   localparam int PIN_ALE = 2;
   localparam int PIN_WE  = 3;
   localparam int PIN_RE  = 4;
   localparam int PIN_WP  = 5;
   localparam int NUM_CTL = 6;
endpackage

// File: rtl/nbd_sync.sv
module nbd_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nbd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/nbd_edge.sv
module nbd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic we_s,
   input  logic re_s,
   output logic we_rise,
   output logic re_fall
);
   logic we_d, re_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         we_d <= 1'b1;
         re_d <= 1'b1;
      end else begin
         we_d <= we_s;
         re_d <= re_s;
      end

   assign we_rise = we_s & ~we_d;
   assign re_fall = re_d & ~re_s;
endmodule

// File: rtl/nbd_classify.sv
module nbd_classify
   import nbd_pkg::*;
#(
   parameter int IO_W = 16
) (
   input  logic            ce_s,
   input  logic            cle_s,
   input  logic            ale_s,
   input  logic            we_s,
   input  logic            re_s,
   input  logic            wp_s,
   input  logic [IO_W-1:0] io_s,
   input  logic            we_rise,
   input  logic            re_fall,
   output logic            hit,
   output cyc_kind_e       kind,
   output logic [IO_W-1:0] data,
   output logic            err
);
   localparam int UPPER_W = IO_W - 8;

   logic upper_nz;

   if (IO_W == 16) begin : g_x16
      assign upper_nz = |io_s[IO_W-1:8];
   end else begin : g_x8
      assign upper_nz = 1'b0;
   end

   logic sel, is_cmd, is_addr, is_din, bad_cmd, both_latch, wr_ok, rd_ok;

   assign sel        = ~ce_s;
   assign both_latch = cle_s & ale_s;
   assign is_cmd     = cle_s & ~ale_s & re_s;
   assign bad_cmd    = cle_s & ~ale_s & ~re_s;
   assign is_addr    = ale_s & ~cle_s;
   assign is_din     = ~cle_s & ~ale_s;
   assign wr_ok      = sel & we_rise & (is_cmd | is_addr | is_din);
   assign rd_ok      = sel & re_fall & ~cle_s & ~ale_s & we_s & ~we_rise;

   logic [IO_W-1:0] low_byte;
   assign low_byte = {{UPPER_W{1'b0}}, io_s[7:0]};

   always_comb begin
      hit  = 1'b0;
      kind = CK_NONE;
      data = '0;
      err  = 1'b0;
      if (sel && we_rise && (both_latch || bad_cmd)) begin
         err = 1'b1;
      end else if (wr_ok) begin
         hit = 1'b1;
         if (!wp_s) begin
            kind = CK_WPROT;
            data = io_s;
         end else if (is_cmd) begin
            kind = CK_CMD;
            data = low_byte;
         end else if (is_addr) begin
            kind = CK_ADDR;
            data = low_byte;
         end else begin
            kind = CK_DIN;
            data = io_s;
         end
         if (is_cmd && upper_nz) err = 1'b1;
      end else if (rd_ok) begin
         hit  = 1'b1;
         kind = CK_DOUT;
      end
   end
endmodule

// File: rtl/nbd_addr_cnt.sv
module nbd_addr_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
endmodule

// File: rtl/nand_cycle_decoder.sv
module nand_cycle_decoder
   import nbd_pkg::*;
#(
   parameter int IO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              cle,
   input  logic              ale,
   input  logic              we_n,
   input  logic              re_n,
   input  logic              wp_n,
   input  logic [IO_W-1:0]   io_in,
   input  logic              busy,
   output logic              cyc_valid,
   output logic [2:0]        cyc_kind,
   output logic [IO_W-1:0]   cyc_data,
   output logic              proto_err,
   output logic              standby,
   output logic [ACNT_W-1:0] addr_count
);
   localparam int VEC_W = NUM_CTL + IO_W;
   localparam logic [VEC_W-1:0] IDLE_VEC =
      VEC_W'((1 << PIN_CE) | (1 << PIN_WE) | (1 << PIN_RE) | (1 << PIN_WP));

   if (IO_W != 8 && IO_W != 16) begin : g_bad_io
      $error("nand_cycle_decoder: IO_W must be 8 or 16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("nand_cycle_decoder: SYNC_STAGES must be 2 or 3");
   end
   if (ACNT_W < 1) begin : g_bad_cnt
      $error("nand_cycle_decoder: ACNT_W must be positive");
   end

   logic [VEC_W-1:0] raw_vec, s_vec;
   assign raw_vec = {io_in, wp_n, re_n, we_n, ale, cle, ce_n};

   nbd_sync #(.W(VEC_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VEC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(s_vec)
   );

   logic we_rise, re_fall;
   nbd_edge u_edge (
      .clk(clk), .rst_n(rst_n),
      .we_s(s_vec[PIN_WE]), .re_s(s_vec[PIN_RE]),
      .we_rise(we_rise), .re_fall(re_fall)
   );

   logic            c_hit, c_err;
   cyc_kind_e       c_kind;
   logic [IO_W-1:0] c_data;

   nbd_classify #(.IO_W(IO_W)) u_cls (
      .ce_s(s_vec[PIN_CE]), .cle_s(s_vec[PIN_CLE]), .ale_s(s_vec[PIN_ALE]),
      .we_s(s_vec[PIN_WE]), .re_s(s_vec[PIN_RE]), .wp_s(s_vec[PIN_WP]),
      .io_s(s_vec[VEC_W-1:NUM_CTL]),
      .we_rise(we_rise), .re_fall(re_fall),
      .hit(c_hit), .kind(c_kind), .data(c_data), .err(c_err)
   );

   nbd_addr_cnt #(.W(ACNT_W)) u_acnt (
      .clk(clk), .rst_n(rst_n),
      .clr(c_hit && c_kind == CK_CMD),
      .inc(c_hit && c_kind == CK_ADDR),
      .cnt(addr_count)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cyc_valid <= 1'b0;
         cyc_kind  <= CK_NONE;
         cyc_data  <= '0;
         proto_err <= 1'b0;
         standby   <= 1'b0;
      end else begin
         cyc_valid <= c_hit;
         cyc_kind  <= c_hit ? c_kind : CK_NONE;
         if (c_hit) cyc_data <= c_data;
         proto_err <= c_err;
         standby   <= s_vec[PIN_CE] & ~busy;
      end
endmodule

// File: rtl/nbd_checker.sv
module nbd_checker #(
   parameter int IO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACNT_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              cle,
   input logic              ale,
   input logic              wp_n,
   input logic              busy,
   input logic              cyc_valid,
   input logic [2:0]        cyc_kind,
   input logic              standby,
   input logic [ACNT_W-1:0] addr_count
);
   localparam int LAT = SYNC_STAGES + 1;
   localparam logic [ACNT_W-1:0] CMAX = {ACNT_W{1'b1}};

   assert_kind_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid == (cyc_kind != 3'd0));

   assert_ce_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> !$past(ce_n, LAT));

   assert_cmd_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_kind == 3'd1) |-> ($past(cle, LAT) && !$past(ale, LAT)));

   assert_addr_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_kind == 3'd2) |-> ($past(ale, LAT) && !$past(cle, LAT)));

   assert_wp_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && (cyc_kind == 3'd1 || cyc_kind == 3'd2 || cyc_kind == 3'd3))
         |-> $past(wp_n, LAT));

   assert_cmd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_kind == 3'd1) |-> addr_count == '0);

   assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_kind == 3'd2) |->
         (addr_count == CMAX || addr_count == $past(addr_count) + 1'b1));

   assert_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> ($past(ce_n, LAT) && !$past(busy)));
endmodule

bind nand_cycle_decoder nbd_checker #(
   .IO_W(IO_W), .SYNC_STAGES(SYNC_STAGES), .ACNT_W(ACNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
   .wp_n(wp_n), .busy(busy), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
   .standby(standby), .addr_count(addr_count)
);

// File: tb/sim_nand_cycle_decoder.sv
`timescale 1ns/1ps
module sim_nand_cycle_decoder;
   localparam int IO_W = 16;
   localparam int ACNT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
   logic [IO_W-1:0] io_in = '0;
   logic busy = 1'b0;
   logic cyc_valid, proto_err, standby;
   logic [2:0] cyc_kind;
   logic [IO_W-1:0] cyc_data;
   logic [ACNT_W-1:0] addr_count;

   int n_checks = 0, n_fail = 0;
   int n_strobe = 0, n_err = 0, n_wide = 0, n_kindbad = 0;
   logic [2:0] last_kind = '0;
   logic [IO_W-1:0] last_data = '0;
   logic prev_valid = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nand_cycle_decoder #(.IO_W(IO_W), .SYNC_STAGES(2), .ACNT_W(ACNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
      .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .busy(busy),
      .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_data(cyc_data),
      .proto_err(proto_err), .standby(standby), .addr_count(addr_count)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (cyc_valid) begin
            n_strobe  <= n_strobe + 1;
            last_kind <= cyc_kind;
            last_data <= cyc_data;
         end
         if (proto_err) n_err <= n_err + 1;
         if (cyc_valid && prev_valid) n_wide <= n_wide + 1;
         if (cyc_valid != (cyc_kind != 3'd0)) n_kindbad <= n_kindbad + 1;
         prev_valid <= cyc_valid;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic go_idle();
      ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1; wp_n = 1'b1;
      io_in = '0;
      wait_clk(4);
   endtask

   task automatic we_cycle(input logic c, input logic a, input logic r,
                           input logic w, input logic [IO_W-1:0] v);
      @(negedge clk);
      ce_n = 1'b0; cle = c; ale = a; re_n = r; wp_n = w; io_in = v;
      wait_clk(3);
      we_n = 1'b0;
      wait_clk(3);
      we_n = 1'b1;
      wait_clk(7);
   endtask

   task automatic t_reset();
      check("R1 valid", cyc_valid, 0);
      check("R1 kind", cyc_kind, 0);
      check("R1 perr", proto_err, 0);
      check("R1 count", addr_count, 0);
   endtask

   task automatic t_cmd();
      int s0 = n_strobe, e0 = n_err;
      we_cycle(1, 0, 1, 1, 16'h0070);
      check("R2 strobes", n_strobe - s0, 1);
      check("R2 kind", last_kind, 1);
      check("R2 data", last_data, 16'h0070);
      check("R6 no err on clean cmd", n_err - e0, 0);
      check("R11 cleared by cmd", addr_count, 0);
      go_idle();
   endtask

   task automatic t_addr();
      int s0 = n_strobe;
      we_cycle(0, 1, 1, 1, 16'h5A3C);
      check("R3 strobes", n_strobe - s0, 1);
      check("R3 kind", last_kind, 2);
      check("R3 data", last_data, 16'h003C);
      go_idle();
   endtask

   task automatic t_din();
      int s0 = n_strobe;
      we_cycle(0, 0, 1, 1, 16'hBEEF);
      check("R4 strobes", n_strobe - s0, 1);
      check("R4 kind", last_kind, 3);
      check("R4 data", last_data, 16'hBEEF);
      go_idle();
   endtask

   task automatic t_dout();
      int s0 = n_strobe;
      @(negedge clk);
      ce_n = 1'b0; io_in = 16'h1234;
      wait_clk(3);
      re_n = 1'b0;
      wait_clk(3);
      re_n = 1'b1;
      wait_clk(7);
      check("R5 strobes", n_strobe - s0, 1);
      check("R5 kind", last_kind, 4);
      check("R5 data", last_data, 0);
      go_idle();
   endtask

   task automatic t_x16err();
      int s0 = n_strobe, e0 = n_err;
      we_cycle(1, 0, 1, 1, 16'h1290);
      check("R6 strobes", n_strobe - s0, 1);
      check("R6 kind", last_kind, 1);
      check("R6 data", last_data, 16'h0090);
      check("R6 err pulses", n_err - e0, 1);
      go_idle();
   endtask

   task automatic t_wp();
      int s0 = n_strobe;
      logic [ACNT_W-1:0] c0 = addr_count;
      we_cycle(0, 0, 1, 0, 16'hA55A);
      check("R7 din strobes", n_strobe - s0, 1);
      check("R7 din kind", last_kind, 5);
      check("R7 din data", last_data, 16'hA55A);
      go_idle();
      we_cycle(0, 1, 1, 0, 16'h0011);
      check("R7 addr kind", last_kind, 5);
      check("R7 count kept", addr_count, c0);
      go_idle();
   endtask

   task automatic t_ce_ignore();
      int s0 = n_strobe;
      @(negedge clk);
      ce_n = 1'b1; cle = 1'b1; io_in = 16'h0090;
      wait_clk(3); we_n = 1'b0; wait_clk(3); we_n = 1'b1; wait_clk(4);
      cle = 1'b0;
      wait_clk(3); re_n = 1'b0; wait_clk(3); re_n = 1'b1; wait_clk(7);
      check("R8 no strobes", n_strobe - s0, 0);
      go_idle();
   endtask

   task automatic t_illegal();
      int s0 = n_strobe, e0 = n_err;
      we_cycle(1, 1, 1, 1, 16'h0044);
      check("R9 both latch strobes", n_strobe - s0, 0);
      check("R9 both latch err", n_err - e0, 1);
      go_idle();
      we_cycle(1, 0, 0, 1, 16'h0044);
      check("R9 cmd re low strobes", n_strobe - s0, 0);
      check("R9 cmd re low err", n_err - e0, 2);
      go_idle();
   endtask

   task automatic t_standby();
      busy = 1'b0; ce_n = 1'b1; wait_clk(6);
      check("R10 standby idle", standby, 1);
      busy = 1'b1; wait_clk(3);
      check("R10 busy blocks", standby, 0);
      busy = 1'b0; ce_n = 1'b0; wait_clk(6);
      check("R10 ce low", standby, 0);
      go_idle();
   endtask

   task automatic t_addr_count();
      we_cycle(1, 0, 1, 1, 16'h0000);
      go_idle();
      for (int i = 0; i < 3; i++) begin
         we_cycle(0, 1, 1, 1, 16'(i));
         go_idle();
      end
      check("R11 three addrs", addr_count, 3);
      for (int i = 0; i < 6; i++) begin
         we_cycle(0, 1, 1, 1, 16'(i));
         go_idle();
      end
      check("R11 saturate", addr_count, 7);
      we_cycle(1, 0, 1, 1, 16'h0030);
      check("R11 cmd clears", addr_count, 0);
      go_idle();
   endtask

   initial begin
      wait_clk(3);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_cmd();
      t_addr();
      t_din();
      t_dout();
      t_x16err();
      t_wp();
      t_ce_ignore();
      t_illegal();
      t_standby();
      t_addr_count();
      check("R12 single clock strobes", n_wide, 0);
      check("R12 kind vs valid", n_kindbad, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule